// File: doc/BRIEF.md
# Five-Port Mesh Router Node

This block is a single switching node of a two-dimensional mesh on-chip network. It has five ports: north, east, south, west, and one local port that connects a processing element. Each port has an enqueue side, where words come in, and a dequeue side, where words go out. Both sides use a FIFO-style handshake. Every word travels with a data field, whose width is set by a parameter, and a control record. The control record holds the source coordinates, the destination coordinates and a word count. Each input has its own sixteen-entry channel buffer.

At the head of each channel buffer, the node decodes the destination from the control record of the first word of a packet. It routes dimension by dimension: the packet first moves along X until the column matches, then along Y, and then it is delivered to the local port. When more than one input wants the same output, a rotating arbiter picks one. The chosen output then stays bound to that input until the number of words named in the length field has passed. A full downstream buffer stalls the transfer. Data is never dropped.

Top module: `mesh_router_node`

## Requirements
- R1: After reset, no output raises its enqueue strobe, no input reports full, and every output is unbound.
- R2: The output port index is computed from the node position (NODE_X, NODE_Y) and the destination (dx, dy). If dx > NODE_X the packet goes east (index 2), and if dx < NODE_X it goes west (4). When the columns match, dy > NODE_Y goes north (1), dy < NODE_Y goes south (3), and an exact match goes to local (0). Input indices use the same numbering.
- R3: The control record is laid out with the source X in bits [1:0], the source Y in [3:2], the destination X in [5:4], the destination Y in [7:6] and the length in [11:8]. It is read only from the first word of a packet. The source fields and the records of later words do not affect routing. Every word of a packet leaves with the first word's record.
- R4: A length field n from 1 to 15 makes the packet exactly n words long. A length field of 0 is carried as a single word.
- R5: Once an output is granted to an input, it carries only that input's words until the packet's word count has passed. No input is ever bound to two outputs at the same time.
- R6: Each output has a round-robin pointer that is 0 after reset. The arbiter grants the first requesting input at or above the pointer, wrapping around. After a grant, the pointer moves to the index just past the winner.
- R7: While an output's full input is high, that output sends nothing. The stalled words stay buffered and later leave in their original order, with none lost.
- R8: An input's full flag rises once its channel buffer holds 16 words and falls again after words leave.
- R9: Take a word written into an empty input whose output is free. Its output strobe rises in the cycle after the clock edge that follows the enqueue edge. It is not already high in the cycle right after the enqueue edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_enq | input | 5 | Per-input write strobe |
| in_data | input | 5*DATA_W | Per-input data words, input i at slice i |
| in_ctrl | input | 5*CTRL_W | Per-input control records |
| in_full | output | 5 | Per-input channel buffer full |
| out_enq | output | 5 | Per-output write strobe toward the neighbour |
| out_data | output | 5*DATA_W | Per-output data words |
| out_ctrl | output | 5*CTRL_W | Per-output control record of the packet in flight |
| out_full | input | 5 | Per-output downstream full, stalls the transfer |

## Verification
The routing function is swept over every destination of a 4x4 mesh from every one of the five inputs, with the source fields varied. This separates the X-first order from a Y-first order, and it catches any use of the source address. A packet train with lengths 1 to 5 shows whether packet boundaries fall exactly where the length fields put them. A packet whose later words carry a different record tells header sampling apart from per-word sampling. Two rounds of simultaneous requests from a known pointer state separate rotating priority from fixed priority. A stalled output with a full input buffer exposes loss, reordering or a wrong full threshold.

// File: rtl/mesh_router_pkg.sv
`timescale 1ns/1ps
package mesh_router_pkg;

  localparam int NUM_PORTS = 5;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  // X first, then Y, then deliver locally
  function automatic logic [2:0] xy_route(input int here_x, input int here_y,
                                          input int dest_x, input int dest_y);
    if (dest_x > here_x) return 3'(DIR_EAST);
    if (dest_x < here_x) return 3'(DIR_WEST);
    if (dest_y > here_y) return 3'(DIR_NORTH);
    if (dest_y < here_y) return 3'(DIR_SOUTH);
    return 3'(DIR_LOCAL);
  endfunction

  // words carried by a packet with the given length field
  function automatic int words_of(input int len_field);
    return (len_field == 0) ? 1 : len_field;
  endfunction

  // round-robin pointer after a grant
  function automatic int rr_after(input int winner, input int n);
    return (winner + 1 >= n) ? 0 : winner + 1;
  endfunction

endpackage

// File: rtl/mr_chan_fifo.sv
`timescale 1ns/1ps
module mr_chan_fifo #(
  parameter int WIDTH = 28,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      fill;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full    = (fill == (AW+1)'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !do_push) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7

endmodule

// File: rtl/mr_out_arb.sv
`timescale 1ns/1ps
module mr_out_arb import mesh_router_pkg::*; #(
  parameter int N_IN    = 5,
  parameter int CTRL_W  = 12,
  parameter int LEN_W   = 4,
  parameter int LEN_LSB = 8,
  localparam int IDX_W  = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        req,
  input  logic [N_IN-1:0]        avail,
  input  logic [N_IN*CTRL_W-1:0] ctrl_all,
  input  logic                   out_full,
  output logic                   out_enq,
  output logic [N_IN-1:0]        pop,
  output logic [IDX_W-1:0]       owner,
  output logic                   locked,
  output logic [CTRL_W-1:0]      held_ctrl
);

  logic [IDX_W-1:0]  ptr;
  logic [IDX_W-1:0]  win;
  logic              found;
  logic [LEN_W:0]    remain;
  logic [CTRL_W-1:0] win_ctrl;
  logic              grant, xfer, last_xfer;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N_IN; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N_IN;
      if (!found && req[idx]) begin
        found = 1'b1;
        win   = IDX_W'(idx);
      end
    end
  end

  assign win_ctrl  = ctrl_all[int'(win)*CTRL_W +: CTRL_W];
  assign grant     = !locked && found;
  assign xfer      = locked && avail[owner] && !out_full;
  assign last_xfer = xfer && (remain == (LEN_W+1)'(1));
  assign out_enq   = xfer;

  always_comb begin
    pop = '0;
    if (xfer) pop[owner] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      owner     <= '0;
      ptr       <= '0;
      remain    <= '0;
      held_ctrl <= '0;
    end else if (grant) begin
      locked    <= 1'b1;
      owner     <= win;
      ptr       <= IDX_W'(rr_after(int'(win), N_IN));
      remain    <= (LEN_W+1)'(words_of(int'(win_ctrl[LEN_LSB +: LEN_W])));
      held_ctrl <= win_ctrl;
    end else if (xfer) begin
      remain <= remain - 1'b1;
      if (last_xfer) locked <= 1'b0;
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !last_xfer) |=> (locked && $stable(owner))); // R5
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !last_xfer) |=> $stable(held_ctrl)); // R3

endmodule

// File: rtl/mesh_router_node.sv
`timescale 1ns/1ps
module mesh_router_node import mesh_router_pkg::*; #(
  parameter int MESH_X     = 4,
  parameter int MESH_Y     = 4,
  parameter int NODE_X     = 1,
  parameter int NODE_Y     = 1,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int COORD_W   = (MESH_X > MESH_Y) ? $clog2(MESH_X) : $clog2(MESH_Y),
  localparam int CTRL_W    = 4*COORD_W + LEN_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        in_enq,
  input  logic [NUM_PORTS*DATA_W-1:0] in_data,
  input  logic [NUM_PORTS*CTRL_W-1:0] in_ctrl,
  output logic [NUM_PORTS-1:0]        in_full,
  output logic [NUM_PORTS-1:0]        out_enq,
  output logic [NUM_PORTS*DATA_W-1:0] out_data,
  output logic [NUM_PORTS*CTRL_W-1:0] out_ctrl,
  input  logic [NUM_PORTS-1:0]        out_full
);

  localparam int ENTRY_W = CTRL_W + DATA_W;
  localparam int IDX_W   = $clog2(NUM_PORTS);
  localparam int LEN_LSB = 4*COORD_W;

  logic [DATA_W-1:0]           head_data [NUM_PORTS];
  logic [CTRL_W-1:0]           head_ctrl [NUM_PORTS];
  logic [ENTRY_W-1:0]          head_entry [NUM_PORTS];
  logic [NUM_PORTS*CTRL_W-1:0] head_ctrl_flat;
  logic [2:0]                  want_dir [NUM_PORTS];
  logic [NUM_PORTS-1:0]        fifo_empty, fifo_pop, busy, locked_v;
  logic [NUM_PORTS-1:0]        req_m [NUM_PORTS];
  logic [NUM_PORTS-1:0]        pop_m [NUM_PORTS];
  logic [NUM_PORTS-1:0]        owned_by [NUM_PORTS];
  logic [IDX_W-1:0]            owner_m [NUM_PORTS];

  // input channels
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    mr_chan_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_enq[i]),
      .wdata ({in_ctrl[i*CTRL_W +: CTRL_W], in_data[i*DATA_W +: DATA_W]}),
      .pop   (fifo_pop[i]),
      .rdata (head_entry[i]),
      .full  (in_full[i]),
      .empty (fifo_empty[i])
    );
    assign head_data[i] = head_entry[i][DATA_W-1:0];
    assign head_ctrl[i] = head_entry[i][ENTRY_W-1:DATA_W];
    assign head_ctrl_flat[i*CTRL_W +: CTRL_W] = head_ctrl[i];
    assign want_dir[i] = xy_route(NODE_X, NODE_Y,
                                  int'(head_ctrl[i][2*COORD_W +: COORD_W]),
                                  int'(head_ctrl[i][3*COORD_W +: COORD_W]));
    assign busy[i] = |owned_by[i];

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owned_by[i])); // R5
  end

  // binding matrix and requests
  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_bind
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_pair
      assign owned_by[i][o] = locked_v[o] && (owner_m[o] == IDX_W'(i));
      assign req_m[o][i]    = !fifo_empty[i] && !busy[i] && (want_dir[i] == 3'(o));
    end
  end

  always_comb begin
    fifo_pop = '0;
    for (int o = 0; o < NUM_PORTS; o++) fifo_pop = fifo_pop | pop_m[o];
  end

  // output arbiters
  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    mr_out_arb #(
      .N_IN    (NUM_PORTS),
      .CTRL_W  (CTRL_W),
      .LEN_W   (LEN_W),
      .LEN_LSB (LEN_LSB)
    ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_m[o]),
      .avail     (~fifo_empty),
      .ctrl_all  (head_ctrl_flat),
      .out_full  (out_full[o]),
      .out_enq   (out_enq[o]),
      .pop       (pop_m[o]),
      .owner     (owner_m[o]),
      .locked    (locked_v[o]),
      .held_ctrl (out_ctrl[o*CTRL_W +: CTRL_W])
    );
    assign out_data[o*DATA_W +: DATA_W] = head_data[owner_m[o]];

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      out_full[o] |-> !pop_m[o][owner_m[o]]); // R7
  end

  AST_POP_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fifo_pop) == $countones(out_enq)); // R7

endmodule

// File: tb/mesh_router_node_tb_top.sv
`timescale 1ns/1ps
module mesh_router_node_tb_top;

  localparam int NP = 5;
  localparam int DW = 16;
  localparam int CW = 12;
  localparam int MX = 1;
  localparam int MY = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic [NP-1:0]    in_enq, in_full, out_enq, out_full;
  logic [NP*DW-1:0] in_data, out_data;
  logic [NP*CW-1:0] in_ctrl, out_ctrl;

  mesh_router_node #(
    .MESH_X(4), .MESH_Y(4), .NODE_X(MX), .NODE_Y(MY),
    .DATA_W(DW), .LEN_W(4), .FIFO_DEPTH(16)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_enq(in_enq), .in_data(in_data), .in_ctrl(in_ctrl), .in_full(in_full),
    .out_enq(out_enq), .out_data(out_data), .out_ctrl(out_ctrl), .out_full(out_full)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int            rp[$];
  logic [CW-1:0] rc[$];
  logic [DW-1:0] rd[$];

  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        if (out_enq[o]) begin
          rp.push_back(o);
          rc.push_back(out_ctrl[o*CW +: CW]);
          rd.push_back(out_data[o*DW +: DW]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk_ctrl(input int sx, input int sy, input int dx,
                                            input int dy, input int len);
    return {4'(len), 2'(dy), 2'(dx), 2'(sy), 2'(sx)};
  endfunction

  function automatic int exp_dir(input int dx, input int dy);
    if (dx != MX) return (dx > MX) ? 2 : 4;
    if (dy != MY) return (dy > MY) ? 1 : 3;
    return 0;
  endfunction

  task automatic clear_rec();
    rp.delete(); rc.delete(); rd.delete();
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_enq = '0; in_data = '0; in_ctrl = '0; out_full = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle(1);
    clear_rec();
  endtask

  task automatic send(input int port, input logic [CW-1:0] first_c,
                      input logic [CW-1:0] later_c, input logic [DW-1:0] base, input int n);
    for (int w = 0; w < n; w++) begin
      in_enq[port] = 1'b1;
      in_data[port*DW +: DW] = base + DW'(w);
      in_ctrl[port*CW +: CW] = (w == 0) ? first_c : later_c;
      @(posedge clk);
      #1;
    end
    in_enq[port] = 1'b0;
  endtask

  // three inputs start 3-word packets to local in the same cycles
  task automatic send_three(input int a, input int b, input int c);
    int pl[3];
    pl[0] = a; pl[1] = b; pl[2] = c;
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 3; k++) begin
        in_enq[pl[k]] = 1'b1;
        in_data[pl[k]*DW +: DW] = {4'(pl[k]), 4'(w), 8'h5A};
        in_ctrl[pl[k]*CW +: CW] = mk_ctrl(pl[k], 0, MX, MY, 3);
      end
      @(posedge clk);
      #1;
    end
    in_enq = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1: reset state
    @(negedge clk);
    check(out_enq == '0, "R1 out_enq after reset", int'(out_enq), 0);
    check(in_full == '0, "R1 in_full after reset", int'(in_full), 0);
    @(posedge clk); #1;

    // R9: first-word latency
    in_enq[0] = 1'b1;
    in_data[0 +: DW] = 16'h1234;
    in_ctrl[0 +: CW] = mk_ctrl(0, 0, 3, 1, 1);
    @(posedge clk); #1;
    in_enq[0] = 1'b0;
    @(negedge clk);
    check(out_enq == '0, "R9 no output one cycle after enqueue", int'(out_enq), 0);
    @(posedge clk);
    @(negedge clk);
    check(out_enq == 5'b00100 && out_data[2*DW +: DW] == 16'h1234,
          "R9 word on east output", int'(out_enq), 4);
    settle(10);
    clear_rec();

    // R2: every destination from every input, source fields varied
    for (int i = 0; i < NP; i++) begin
      for (int d = 0; d < 16; d++) begin
        int dx, dy, ex;
        dx = d % 4; dy = d / 4; ex = exp_dir(dx, dy);
        send(i, mk_ctrl(3 - dx, (d + i) % 4, dx, dy, 1), '0, DW'(i*256 + d), 1);
        settle(6);
        check(rp.size() == 1 && rp[0] == ex && rd[0] == DW'(i*256 + d),
              "R2 xy route", (rp.size() == 1) ? rp[0] : -1, ex);
        clear_rec();
      end
    end

    // R3: only the first record steers and is carried by every word
    send(4, mk_ctrl(2, 2, 1, 1, 3), mk_ctrl(0, 0, 3, 3, 3), 16'hC000, 3);
    settle(12);
    check(rp.size() == 3, "R3 word count", rp.size(), 3);
    for (int k = 0; k < 3 && k < rp.size(); k++)
      check(rp[k] == 0 && rc[k] == mk_ctrl(2, 2, 1, 1, 3),
            "R3 local delivery with first record", int'(rc[k]), int'(mk_ctrl(2, 2, 1, 1, 3)));
    clear_rec();

    // R4: packet train with lengths 1..5 north to west
    for (int l = 1; l <= 5; l++)
      send(1, mk_ctrl(1, 3, 0, 1, l), mk_ctrl(1, 3, 0, 1, l), {8'(l), 8'h00}, l);
    settle(40);
    check(rp.size() == 15, "R4 total words", rp.size(), 15);
    for (int k = 0; k < rp.size(); k++)
      check(rp[k] == 4 && int'(rc[k][11:8]) == int'(rd[k][15:8]),
            "R4 word inside its packet", int'(rc[k][11:8]), int'(rd[k][15:8]));
    clear_rec();

    // R5, R6: round robin from a known pointer
    do_reset();
    send_three(1, 2, 3);
    settle(40);
    check(rp.size() == 9, "R5 words first round", rp.size(), 9);
    for (int k = 0; k < 9 && k < rp.size(); k++)
      check(rp[k] == 0 && int'(rd[k][15:12]) == 1 + k/3 && int'(rd[k][11:8]) == k % 3,
            "R6 R5 order first round", int'(rd[k][15:12]), 1 + k/3);
    clear_rec();
    send_three(0, 2, 4);
    settle(40);
    check(rp.size() == 9, "R5 words second round", rp.size(), 9);
    for (int k = 0; k < 9 && k < rp.size(); k++) begin
      int es;
      es = (k < 3) ? 4 : (k < 6) ? 0 : 2;
      check(rp[k] == 0 && int'(rd[k][15:12]) == es && int'(rd[k][11:8]) == k % 3,
            "R6 R5 order second round", int'(rd[k][15:12]), es);
    end
    clear_rec();

    // R7, R8: stall local output, fill the east channel
    do_reset();
    out_full[0] = 1'b1;
    send(2, mk_ctrl(2, 1, 1, 1, 8), mk_ctrl(2, 1, 1, 1, 8), 16'hB000, 8);
    @(negedge clk);
    check(in_full[2] == 1'b0, "R8 not full at 8 words", int'(in_full[2]), 0);
    @(posedge clk); #1;
    send(2, mk_ctrl(2, 1, 1, 1, 8), mk_ctrl(2, 1, 1, 1, 8), 16'hB008, 8);
    settle(5);
    check(in_full[2] == 1'b1, "R8 full at 16 words", int'(in_full[2]), 1);
    check(rp.size() == 0, "R7 nothing sent while stalled", rp.size(), 0);
    out_full[0] = 1'b0;
    settle(40);
    check(in_full[2] == 1'b0, "R8 full clears after drain", int'(in_full[2]), 0);
    check(rp.size() == 16, "R7 all stalled words delivered", rp.size(), 16);
    for (int k = 0; k < 16 && k < rp.size(); k++)
      check(rp[k] == 0 && rd[k] == 16'hB000 + DW'(k), "R7 order after stall",
            int'(rd[k]), 16'hB000 + k);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule